// File: doc/BRIEF.md
# Cluster Coherence Bus Filter

This block sits at the boundary between one cluster's local bus and the global bus of a machine whose main memory is split across clusters. It watches every transaction on both buses and decides whether that transaction has to cross the boundary. Local-bus traffic is passed upward only when the line's home is elsewhere or when another cluster holds a copy that matters. Global-bus writes are passed downward only when this cluster's memory or one of its caches is affected. It moves no data. It keeps only a tag table of lines that have copies away from their home.

The home cluster of a line is the top `CL_W` bits of its address, compared with the parameter `MY_CLUSTER`. The table is direct-mapped with `2**IDX_W` entries. Each entry holds a valid bit, a tag and two status bits. `cpy` means a copy exists on the far side of the boundary from the line's home: in other clusters for a locally homed line, and in this cluster for a remotely homed line. `dirty` means that copy is modified. When both buses present a request in the same cycle, the global one is taken and the local requester is refused for that cycle.

Top module: `cluster_coh_filter`

## Requirements
- R1: A local request is accepted (`loc_gnt`=1) only when `loc_vld`=1 and `glb_vld`=0. When both buses are valid in the same cycle, only the global transaction is processed.
- R2: From reset all outputs are 0 and the table is empty. An accepted transaction appears on the outputs exactly two clock edges after the edge that captures it, with `out_vld`=1 and its address and op echoed. `out_src` is 0 for local and 1 for global, and op 0 is a read and op 1 a write. `out_up` is set only for local transactions and `out_down` only for global ones. `out_cpy`/`out_dirty` give the line's tracked state after the update, and dirty never appears without a copy.
- R3: A local write to a remotely homed line is always forwarded up. Afterwards the line is tracked with a copy and dirty.
- R4: A local write to a locally homed line is forwarded up only if the line is tracked with a remote copy. Afterwards the line is untracked (cpy=0, dirty=0).
- R5: A local read to a remotely homed line is forwarded up unless the line is tracked with a copy in this cluster. After a forwarded read the line is tracked with a clean copy, and after an unforwarded read its state is unchanged.
- R6: A local read to a locally homed line is forwarded up only if the line is tracked dirty remotely. Afterwards the dirty bit is clear and the copy bit is kept.
- R7: A global write to a locally homed line is always passed down. Afterwards the line is tracked with a copy and dirty.
- R8: A global write to a remotely homed line is passed down only if the line is tracked dirty in this cluster. Afterwards the line is untracked.
- R9: A global read is never forwarded in either direction. It marks a locally homed line as having a clean remote copy and leaves a remotely homed line's state unchanged.
- R10: The table index is address bits `[OFS_W+IDX_W-1:OFS_W]` and the tag is the top `ADDR_W-OFS_W-IDX_W` bits. A transaction whose resulting state has a copy overwrites the entry at its index, dropping any other line held there. A transaction that misses and leaves no copy does not disturb the entry.
- R11: A transaction to a line immediately after another transaction to the same line sees the earlier update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loc_vld | input | 1 | Local-bus transaction present |
| loc_addr | input | ADDR_W | Local-bus address |
| loc_op | input | 1 | Local-bus op, 0 read, 1 write |
| loc_gnt | output | 1 | Local transaction accepted this cycle |
| glb_vld | input | 1 | Global-bus transaction present |
| glb_addr | input | ADDR_W | Global-bus address |
| glb_op | input | 1 | Global-bus op, 0 read, 1 write |
| out_vld | output | 1 | A processed transaction is reported |
| out_src | output | 1 | Source bus of the reported transaction, 0 local, 1 global |
| out_addr | output | ADDR_W | Address of the reported transaction |
| out_op | output | 1 | Op of the reported transaction |
| out_up | output | 1 | Forward to the global bus |
| out_down | output | 1 | Forward to the local bus |
| out_cpy | output | 1 | Line tracked with a copy away from home after the update |
| out_dirty | output | 1 | That copy is modified after the update |

## Verification
The properties assume that reset is asserted from time zero and that the valid, address and op inputs hold known values on every clock edge after it. They also assume a local request counts as taken only in a cycle where `loc_gnt` is high, since a refused one simply vanishes. The stimulus drives every input at each falling edge and draws addresses from a small pool that collides on a few table indices. This gives hits, conflict evictions and same-line back-to-back pairs. A refused local request is not replayed, so the reference model only sees what the block accepted.

// File: rtl/ccf_pkg.sv
package ccf_pkg;
  typedef enum logic { OP_RD = 1'b0, OP_WR = 1'b1 } op_t;
  typedef enum logic { SRC_LOC = 1'b0, SRC_GLB = 1'b1 } src_t;
endpackage

// File: rtl/ccf_arb.sv
// Picks one transaction per cycle; the global bus always wins.
module ccf_arb #(
  parameter int ADDR_W = 16
) (
  input  logic              loc_vld,
  input  logic [ADDR_W-1:0] loc_addr,
  input  logic              loc_op,
  input  logic              glb_vld,
  input  logic [ADDR_W-1:0] glb_addr,
  input  logic              glb_op,
  output logic              sel_vld,
  output logic              sel_src,
  output logic [ADDR_W-1:0] sel_addr,
  output logic              sel_op,
  output logic              loc_gnt
);
  always_comb begin
    sel_vld  = glb_vld | loc_vld;
    sel_src  = glb_vld;
    sel_addr = glb_vld ? glb_addr : loc_addr;
    sel_op   = glb_vld ? glb_op : loc_op;
    loc_gnt  = loc_vld & ~glb_vld;
  end
endmodule

// File: rtl/ccf_tagram.sv
// Tag store: RAM-style body with synchronous read, valid bits in flops,
// and a registered bypass for a read that meets the same-cycle write.
module ccf_tagram #(
  parameter int IDX_W = 6,
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_vld,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             wr_cpy,
  input  logic             wr_dirty,
  output logic             ent_vld,
  output logic [TAG_W-1:0] ent_tag,
  output logic             ent_cpy,
  output logic             ent_dirty
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int DW    = TAG_W + 2;

  logic [DW-1:0]    body [DEPTH];
  logic [DEPTH-1:0] vbits;
  logic [DW-1:0]    rd_q;
  logic             vld_q;
  logic             byp_hit;
  logic             byp_vld;
  logic [DW-1:0]    byp_dat;
  logic [DW-1:0]    wr_dat;
  logic [DW-1:0]    sel_dat;

  assign wr_dat = {wr_cpy, wr_dirty, wr_tag};

  always_ff @(posedge clk) begin
    if (wr_en) body[wr_idx] <= wr_dat;
    rd_q <= body[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vbits   <= '0;
      vld_q   <= 1'b0;
      byp_hit <= 1'b0;
      byp_vld <= 1'b0;
      byp_dat <= '0;
    end else begin
      if (wr_en) vbits[wr_idx] <= wr_vld;
      vld_q   <= vbits[rd_idx];
      byp_hit <= wr_en && (wr_idx == rd_idx);
      byp_vld <= wr_vld;
      byp_dat <= wr_dat;
    end
  end

  always_comb begin
    sel_dat   = byp_hit ? byp_dat : rd_q;
    ent_vld   = byp_hit ? byp_vld : vld_q;
    ent_cpy   = sel_dat[DW-1];
    ent_dirty = sel_dat[DW-2];
    ent_tag   = sel_dat[TAG_W-1:0];
  end
endmodule

// File: rtl/ccf_decide.sv
// Forwarding and next-state rules for one transaction.
module ccf_decide
  import ccf_pkg::*;
(
  input  src_t src,
  input  op_t  op,
  input  logic home_loc,
  input  logic cur_cpy,
  input  logic cur_dirty,
  output logic fwd_up,
  output logic fwd_down,
  output logic nxt_cpy,
  output logic nxt_dirty
);
  always_comb begin
    fwd_up    = 1'b0;
    fwd_down  = 1'b0;
    nxt_cpy   = cur_cpy;
    nxt_dirty = cur_dirty;
    if (src == SRC_LOC) begin
      if (op == OP_WR) begin
        if (home_loc) begin
          fwd_up    = cur_cpy;
          nxt_cpy   = 1'b0;
          nxt_dirty = 1'b0;
        end else begin
          fwd_up    = 1'b1;
          nxt_cpy   = 1'b1;
          nxt_dirty = 1'b1;
        end
      end else begin
        if (home_loc) begin
          fwd_up    = cur_dirty;
          nxt_dirty = 1'b0;
        end else begin
          fwd_up    = ~cur_cpy;
          nxt_cpy   = 1'b1;
          nxt_dirty = cur_cpy & cur_dirty;
        end
      end
    end else begin
      if (op == OP_WR) begin
        if (home_loc) begin
          fwd_down  = 1'b1;
          nxt_cpy   = 1'b1;
          nxt_dirty = 1'b1;
        end else begin
          fwd_down  = cur_dirty;
          nxt_cpy   = 1'b0;
          nxt_dirty = 1'b0;
        end
      end else if (home_loc) begin
        nxt_cpy   = 1'b1;
        nxt_dirty = 1'b0;
      end
    end
  end
endmodule

// File: rtl/cluster_coh_filter.sv
module cluster_coh_filter
  import ccf_pkg::*;
#(
  parameter int              ADDR_W     = 16,
  parameter int              OFS_W      = 4,
  parameter int              IDX_W      = 6,
  parameter int              CL_W       = 2,
  parameter logic [CL_W-1:0] MY_CLUSTER = CL_W'(1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loc_vld,
  input  logic [ADDR_W-1:0] loc_addr,
  input  logic              loc_op,
  output logic              loc_gnt,
  input  logic              glb_vld,
  input  logic [ADDR_W-1:0] glb_addr,
  input  logic              glb_op,
  output logic              out_vld,
  output logic              out_src,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_op,
  output logic              out_up,
  output logic              out_down,
  output logic              out_cpy,
  output logic              out_dirty
);
  localparam int TAG_W = ADDR_W - OFS_W - IDX_W;

  // stage 0: arbitration
  logic              sel_vld, sel_src, sel_op;
  logic [ADDR_W-1:0] sel_addr;

  ccf_arb #(.ADDR_W(ADDR_W)) u_arb (
    .loc_vld (loc_vld),  .loc_addr(loc_addr), .loc_op(loc_op),
    .glb_vld (glb_vld),  .glb_addr(glb_addr), .glb_op(glb_op),
    .sel_vld (sel_vld),  .sel_src (sel_src),  .sel_addr(sel_addr),
    .sel_op  (sel_op),   .loc_gnt (loc_gnt)
  );

  // stage 1: table lookup result available
  logic              s1_vld, s1_src, s1_op;
  logic [ADDR_W-1:0] s1_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld  <= 1'b0;
      s1_src  <= 1'b0;
      s1_op   <= 1'b0;
      s1_addr <= '0;
    end else begin
      s1_vld  <= sel_vld;
      s1_src  <= sel_src;
      s1_op   <= sel_op;
      s1_addr <= sel_addr;
    end
  end

  logic [IDX_W-1:0] s1_idx;
  logic [TAG_W-1:0] s1_tag;
  logic             s1_home_loc;
  logic             ent_vld, ent_cpy, ent_dirty;
  logic [TAG_W-1:0] ent_tag;
  logic             hit, cur_cpy, cur_dirty;
  logic             fwd_up, fwd_down, nxt_cpy, nxt_dirty;
  logic             wr_en;

  assign s1_idx      = s1_addr[OFS_W +: IDX_W];
  assign s1_tag      = s1_addr[ADDR_W-1 -: TAG_W];
  assign s1_home_loc = (s1_addr[ADDR_W-1 -: CL_W] == MY_CLUSTER);
  assign hit         = ent_vld && (ent_tag == s1_tag);
  assign cur_cpy     = hit & ent_cpy;
  assign cur_dirty   = hit & ent_dirty;
  assign wr_en       = s1_vld && (nxt_cpy || hit);

  ccf_tagram #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk     (clk),
    .rst     (rst),
    .rd_idx  (sel_addr[OFS_W +: IDX_W]),
    .wr_en   (wr_en),
    .wr_idx  (s1_idx),
    .wr_vld  (nxt_cpy),
    .wr_tag  (s1_tag),
    .wr_cpy  (nxt_cpy),
    .wr_dirty(nxt_dirty),
    .ent_vld (ent_vld),
    .ent_tag (ent_tag),
    .ent_cpy (ent_cpy),
    .ent_dirty(ent_dirty)
  );

  ccf_decide u_dec (
    .src      (src_t'(s1_src)),
    .op       (op_t'(s1_op)),
    .home_loc (s1_home_loc),
    .cur_cpy  (cur_cpy),
    .cur_dirty(cur_dirty),
    .fwd_up   (fwd_up),
    .fwd_down (fwd_down),
    .nxt_cpy  (nxt_cpy),
    .nxt_dirty(nxt_dirty)
  );

  // stage 2: registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld   <= 1'b0;
      out_src   <= 1'b0;
      out_addr  <= '0;
      out_op    <= 1'b0;
      out_up    <= 1'b0;
      out_down  <= 1'b0;
      out_cpy   <= 1'b0;
      out_dirty <= 1'b0;
    end else begin
      out_vld   <= s1_vld;
      out_src   <= s1_src;
      out_addr  <= s1_addr;
      out_op    <= s1_op;
      out_up    <= s1_vld & fwd_up;
      out_down  <= s1_vld & fwd_down;
      out_cpy   <= s1_vld & nxt_cpy;
      out_dirty <= s1_vld & nxt_dirty;
    end
  end
endmodule

// File: rtl/ccf_chk.sv
module ccf_chk #(
  parameter int              ADDR_W     = 16,
  parameter int              CL_W       = 2,
  parameter logic [CL_W-1:0] MY_CLUSTER = CL_W'(1)
) (
  input logic              clk,
  input logic              rst,
  input logic              loc_vld,
  input logic              loc_gnt,
  input logic              glb_vld,
  input logic              out_vld,
  input logic              out_src,
  input logic [ADDR_W-1:0] out_addr,
  input logic              out_op,
  input logic              out_up,
  input logic              out_down,
  input logic              out_cpy,
  input logic              out_dirty
);
  logic home_loc;
  assign home_loc = (out_addr[ADDR_W-1 -: CL_W] == MY_CLUSTER);

  a_r1_glb_wins: assert property (@(posedge clk) disable iff (rst)
    glb_vld |-> !loc_gnt);
  a_r1_gnt_needs_req: assert property (@(posedge clk) disable iff (rst)
    loc_gnt |-> loc_vld);
  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    (glb_vld || loc_gnt) |-> ##2 out_vld);
  a_r2_idle: assert property (@(posedge clk) disable iff (rst)
    (!glb_vld && !loc_vld) |-> ##2 !out_vld);
  a_r2_up_from_local: assert property (@(posedge clk) disable iff (rst)
    out_up |-> (out_vld && !out_src));
  a_r2_down_from_global: assert property (@(posedge clk) disable iff (rst)
    out_down |-> (out_vld && out_src));
  a_r2_dirty_has_copy: assert property (@(posedge clk) disable iff (rst)
    out_dirty |-> out_cpy);
  a_r3_remote_local_write: assert property (@(posedge clk) disable iff (rst)
    (out_vld && !out_src && out_op && !home_loc) |-> (out_up && out_cpy && out_dirty));
  a_r7_local_global_write: assert property (@(posedge clk) disable iff (rst)
    (out_vld && out_src && out_op && home_loc) |-> (out_down && out_dirty));
  a_r9_global_read_quiet: assert property (@(posedge clk) disable iff (rst)
    (out_vld && out_src && !out_op) |-> (!out_down && !out_up));
  a_r4_local_write_clears: assert property (@(posedge clk) disable iff (rst)
    (out_vld && !out_src && out_op && home_loc) |-> (!out_cpy && !out_dirty));
endmodule

bind cluster_coh_filter ccf_chk #(
  .ADDR_W(ADDR_W), .CL_W(CL_W), .MY_CLUSTER(MY_CLUSTER)
) u_chk (
  .clk(clk), .rst(rst), .loc_vld(loc_vld), .loc_gnt(loc_gnt), .glb_vld(glb_vld),
  .out_vld(out_vld), .out_src(out_src), .out_addr(out_addr), .out_op(out_op),
  .out_up(out_up), .out_down(out_down), .out_cpy(out_cpy), .out_dirty(out_dirty)
);

// File: tb/sim_cluster_coh_filter.sv
module sim_cluster_coh_filter;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16, OFS_W = 4, IDX_W = 6, CL_W = 2;
  localparam int TAG_W = AW - OFS_W - IDX_W;
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CL_W-1:0] MY = CL_W'(1);

  logic clk = 1'b0, rst = 1'b1;
  logic loc_vld = 1'b0, loc_op = 1'b0, glb_vld = 1'b0, glb_op = 1'b0;
  logic [AW-1:0] loc_addr = '0, glb_addr = '0;
  logic loc_gnt, out_vld, out_src, out_op, out_up, out_down, out_cpy, out_dirty;
  logic [AW-1:0] out_addr;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cluster_coh_filter #(.ADDR_W(AW), .OFS_W(OFS_W), .IDX_W(IDX_W), .CL_W(CL_W),
                       .MY_CLUSTER(MY)) u0 (
    .clk(clk), .rst(rst), .loc_vld(loc_vld), .loc_addr(loc_addr), .loc_op(loc_op),
    .loc_gnt(loc_gnt), .glb_vld(glb_vld), .glb_addr(glb_addr), .glb_op(glb_op),
    .out_vld(out_vld), .out_src(out_src), .out_addr(out_addr), .out_op(out_op),
    .out_up(out_up), .out_down(out_down), .out_cpy(out_cpy), .out_dirty(out_dirty)
  );

  typedef struct {
    bit            v;
    bit            src;
    bit            op;
    logic [AW-1:0] addr;
    bit            up, down, cpy, dirty;
    string         rq;
  } exp_t;

  // reference table
  bit               m_vld [DEPTH];
  logic [TAG_W-1:0] m_tag [DEPTH];
  bit               m_cpy [DEPTH];
  bit               m_dirty [DEPTH];

  exp_t e1, e2;

  task automatic chk(input string rq, input string what, input logic [31:0] act,
                     input logic [31:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp_v);
    end
  endtask

  function automatic logic [AW-1:0] mk(input int h, input int t, input int i);
    return {2'(h), 2'b00, 2'(t), 6'(i), 4'h0};
  endfunction

  // Expected outcome straight from the requirement rules
  task automatic predict(input bit src, input bit op, input logic [AW-1:0] a, output exp_t e);
    int               ix;
    logic [TAG_W-1:0] tg;
    bit               hl, hit, c, d, nc, nd, up, dn;
    ix = int'(a[OFS_W +: IDX_W]);
    tg = a[AW-1 -: TAG_W];
    hl = (a[AW-1 -: CL_W] == MY);
    hit = m_vld[ix] && (m_tag[ix] == tg);
    c = hit && m_cpy[ix];
    d = hit && m_dirty[ix];
    up = 0; dn = 0; nc = c; nd = d;
    if (!src && op) begin
      if (hl) begin up = c; nc = 0; nd = 0; e.rq = "R4"; end       // R4
      else begin up = 1; nc = 1; nd = 1; e.rq = "R3"; end          // R3
    end else if (!src && !op) begin
      if (hl) begin up = d; nd = 0; e.rq = "R6"; end               // R6
      else begin
        e.rq = "R5";                                               // R5
        if (c) up = 0; else begin up = 1; nc = 1; nd = 0; end
      end
    end else if (src && op) begin
      if (hl) begin dn = 1; nc = 1; nd = 1; e.rq = "R7"; end       // R7
      else begin dn = d; nc = 0; nd = 0; e.rq = "R8"; end          // R8
    end else begin
      e.rq = "R9";                                                 // R9
      if (hl) begin nc = 1; nd = 0; end
    end
    if (nc) begin
      m_vld[ix] = 1; m_tag[ix] = tg; m_cpy[ix] = 1; m_dirty[ix] = nd;
    end else if (hit) begin
      m_vld[ix] = 0;
    end
    e.v = 1; e.src = src; e.op = op; e.addr = a;
    e.up = up; e.down = dn; e.cpy = nc; e.dirty = nd;
  endtask

  // One cycle: check outputs of two cycles ago, drive, check grant, predict.
  task automatic step(input bit lv, input logic [AW-1:0] la, input bit lo,
                      input bit gv, input logic [AW-1:0] ga, input bit go,
                      input string tag = "");
    exp_t ne;
    if (e2.v) begin
      chk("R2", "out_vld", 32'(out_vld), 1);
      chk("R2", "out_src", 32'(out_src), 32'(e2.src));
      chk("R2", "out_addr", 32'(out_addr), 32'(e2.addr));
      chk("R2", "out_op", 32'(out_op), 32'(e2.op));
      chk(e2.rq, "out_up", 32'(out_up), 32'(e2.up));
      chk(e2.rq, "out_down", 32'(out_down), 32'(e2.down));
      chk(e2.rq, "out_cpy", 32'(out_cpy), 32'(e2.cpy));
      chk(e2.rq, "out_dirty", 32'(out_dirty), 32'(e2.dirty));
    end else begin
      chk("R2", "idle out_vld", 32'(out_vld), 0);
      chk("R2", "idle out_up", 32'(out_up), 0);
      chk("R2", "idle out_down", 32'(out_down), 0);
    end
    loc_vld = lv; loc_addr = la; loc_op = lo;
    glb_vld = gv; glb_addr = ga; glb_op = go;
    #1;
    chk("R1", "loc_gnt", 32'(loc_gnt), 32'(lv && !gv));
    ne.v = 0; ne.rq = "R2";
    if (gv) predict(1'b1, go, ga, ne);
    else if (lv) predict(1'b0, lo, la, ne);
    if (ne.v && tag != "") ne.rq = tag;
    e2 = e1;
    e1 = ne;
    @(negedge clk);
  endtask

  function automatic logic [AW-1:0] raddr();
    return {2'($urandom_range(0, 3)), 2'b00, 2'($urandom_range(0, 1)),
            6'($urandom_range(0, 3)), 4'($urandom_range(0, 15))};
  endfunction

  initial begin
    int unsigned seed;
    seed = $urandom(32'h1c0de);
    e1.v = 0; e2.v = 0; e1.rq = "R2"; e2.rq = "R2";
    for (int i = 0; i < DEPTH; i++) begin
      m_vld[i] = 0; m_tag[i] = '0; m_cpy[i] = 0; m_dirty[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R2: reset state
    chk("R2", "reset out_vld", 32'(out_vld), 0);
    chk("R2", "reset out_cpy", 32'(out_cpy), 0);
    chk("R2", "reset out_addr", 32'(out_addr), 0);

    // directed cases
    step(1, mk(2,0,8), 1,  0, '0, 0);          // R3 remote write
    step(1, mk(2,0,8), 0,  0, '0, 0, "R11");   // R5 hit, back-to-back
    step(1, mk(3,0,9), 0,  0, '0, 0);          // R5 miss
    step(0, '0, 0,  1, mk(3,0,9), 1);          // R8 clean held
    step(0, '0, 0,  1, mk(2,0,8), 1);          // R8 dirty held
    step(0, '0, 0,  1, mk(1,0,10), 1);         // R7
    step(0, '0, 0,  0, '0, 0);
    step(1, mk(1,0,10), 0,  0, '0, 0);         // R6 recall
    step(1, mk(1,0,10), 0,  0, '0, 0);         // R6 now clean
    step(1, mk(1,0,10), 1,  0, '0, 0);         // R4 remote copy
    step(1, mk(1,0,10), 1,  0, '0, 0);         // R4 untracked
    step(0, '0, 0,  1, mk(1,1,11), 0);         // R9 local home
    step(0, '0, 0,  1, mk(2,0,8), 0);          // R9 remote home
    step(0, '0, 0,  1, mk(1,0,12), 1);         // R7
    step(1, mk(1,0,12), 0,  0, '0, 0, "R11");  // sees dirty just written
    step(0, '0, 0,  1, mk(1,0,20), 0);         // R10 allocate
    step(0, '0, 0,  1, mk(1,1,20), 0);         // R10 evict
    step(1, mk(1,0,20), 1,  0, '0, 0, "R10");  // evicted line forgotten
    step(1, mk(2,0,21), 0,  0, '0, 0);         // allocate remote line
    step(1, mk(1,0,21), 1,  0, '0, 0);         // miss, no copy
    step(1, mk(2,0,21), 0,  0, '0, 0, "R10");  // entry survived
    step(1, mk(2,0,30), 1,  1, mk(1,0,30), 1); // R1 collision
    step(1, mk(2,0,30), 1,  0, '0, 0);

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      bit lv, gv;
      lv = ($urandom_range(0, 9) < 6);
      gv = ($urandom_range(0, 9) < 3);
      step(lv, raddr(), 1'($urandom_range(0, 1)), gv, raddr(), 1'($urandom_range(0, 1)));
    end
    step(0, '0, 0, 0, '0, 0);
    step(0, '0, 0, 0, '0, 0);
    step(0, '0, 0, 0, '0, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule